// File: doc/BRIEF.md
# TLB Array Access Port

This block gives software a load/store window onto two translation buffers held as flops: a small instruction buffer (4 entries) and a larger unified buffer (64 entries). Every entry holds an address word (virtual page number in bits [31:10], address-space tag in bits [7:0]), separate valid and dirty flags, a 32-bit data word whose bit 1 marks the page as shared, and a 4-bit assistance field. The top byte of the bus address picks which array is touched. The low address bits pick the entry.

Writes to the unified address array come in two kinds. An indexed write replaces a single entry. An associative write compares its page number against all 68 entries in one cycle and rewrites the valid and dirty flags of every entry that matches. Each entry that any write changes raises a one-cycle sync pulse, so that a lookup cache further down the line can reload it. Reads return one 32-bit word one cycle after the request.

Top module: `tlb_mmio_port`

## Requirements
- R1: Only region codes 0xF2 (instruction address array), 0xF3 (instruction data array), 0xF6 (unified address array) and 0xF7 (unified data array) in addr_i[31:24] are decoded. A read of any other code returns 0. A write to any other code changes no entry and raises no sync pulse.
- R2: The instruction entry index is addr_i[9:8]. The unified entry index is addr_i[13:8].
- R3: An address-array read returns the stored address word with the valid flag in bit 8. For the unified array the dirty flag is also in bit 9. For the instruction array bit 9 reads as 0.
- R4: An indexed address-array write stores wdata_i & 0xFFFFFCFF and loads valid from wdata_i[8]. A unified write also loads dirty from wdata_i[9]. On 0xF6 a write is indexed when addr_i[7] is 0. On 0xF2 a write is always indexed.
- R5: A write to 0xF6 with addr_i[7] set is associative. An entry of either array matches when it is valid, its address word bits [31:10] equal wdata_i[31:10], and either its data-word bit 1 is set or its address word bits [7:0] equal cur_asid_i. Every matching entry takes valid from wdata_i[8] and dirty from wdata_i[9]. Non-matching entries keep their state.
- R6: A data-array write with addr_i[23] set stores only wdata_i[3:0] into the assistance field and leaves the data word unchanged. With addr_i[23] clear, it stores the full 32-bit word and leaves the assistance field unchanged.
- R7: A data-array read returns the entry's full data word when addr_i[23] is 0. When addr_i[23] is 1 it returns the assistance field zero-extended.
- R8: The cycle after a write, itlb_sync_o/utlb_sync_o pulse for exactly the entries that write touched. They are all 0 after a read or an idle cycle.
- R9: After reset every word, flag and field is 0, rdata_o is 0 and no sync bit is set.
- R10: rdata_o shows the read result one clock after the request cycle and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Access address: region, selectors, index |
| wdata_i | input | 32 | Write data |
| cur_asid_i | input | 8 | Current address-space tag, used by the associative compare |
| rdata_o | output | 32 | Registered read data |
| itlb_sync_o | output | 4 | Per-entry update pulse, instruction array |
| utlb_sync_o | output | 64 | Per-entry update pulse, unified array |

## Verification
The assertions assume that the decoded write strobes are mutually exclusive, and that req_i, we_i, addr_i and wdata_i are free of X in any cycle where req_i is high. The stimulus drives one access per request cycle, holds all inputs at 0 outside requests and during reset, and never overlaps two accesses. Page numbers and address-space tags are drawn from small pools. This makes associative writes hit one entry, several entries, or none, across both arrays, and it exercises both the shared-page path and the tag-match path.

// File: rtl/tlb_port_pkg.sv
package tlb_port_pkg;

  typedef enum logic [7:0] {
    RG_IADDR = 8'hF2,
    RG_IDATA = 8'hF3,
    RG_UADDR = 8'hF6,
    RG_UDATA = 8'hF7
  } region_e;

  typedef enum logic [2:0] {
    RD_NONE, RD_IADDR, RD_IDATA, RD_IASST, RD_UADDR, RD_UDATA, RD_UASST
  } rd_src_e;

  typedef struct packed {
    logic i_addr_we;
    logic i_data_we;
    logic i_asst_we;
    logic u_addr_we;
    logic u_data_we;
    logic u_asst_we;
    logic assoc_we;
  } wr_sel_t;

  localparam logic [31:0] ADDR_KEEP = 32'hFFFF_FCFF;
  localparam int unsigned VLD_BIT   = 8;
  localparam int unsigned DRT_BIT   = 9;

endpackage

// File: rtl/tlb_port_decode.sv
module tlb_port_decode
  import tlb_port_pkg::*;
(
  input  logic       req_i,
  input  logic       we_i,
  input  logic [7:0] region_i,
  input  logic       part_sel_i,
  input  logic       assoc_sel_i,
  output wr_sel_t    wsel_o,
  output rd_src_e    rsel_o
);

  always_comb begin
    wsel_o = '0;
    rsel_o = RD_NONE;
    if (req_i) begin
      case (region_i)
        RG_IADDR: if (we_i) wsel_o.i_addr_we = 1'b1;
                  else      rsel_o = RD_IADDR;
        RG_IDATA: if (we_i) begin
                    wsel_o.i_asst_we = part_sel_i;
                    wsel_o.i_data_we = !part_sel_i;
                  end else rsel_o = part_sel_i ? RD_IASST : RD_IDATA;
        RG_UADDR: if (we_i) begin
                    wsel_o.assoc_we  = assoc_sel_i;
                    wsel_o.u_addr_we = !assoc_sel_i;
                  end else rsel_o = RD_UADDR;
        RG_UDATA: if (we_i) begin
                    wsel_o.u_asst_we = part_sel_i;
                    wsel_o.u_data_we = !part_sel_i;
                  end else rsel_o = part_sel_i ? RD_UASST : RD_UDATA;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/tlb_entry_bank.sv
module tlb_entry_bank
  import tlb_port_pkg::*;
#(
  parameter int unsigned ENTRIES    = 4,
  parameter bit          HAS_DIRTY  = 1'b0,
  parameter int unsigned VPN_LSB    = 10,
  parameter int unsigned ASID_W     = 8,
  parameter int unsigned SHARED_BIT = 1,
  parameter int unsigned ASST_W     = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [$clog2(ENTRIES)-1:0] idx_i,
  input  logic                       addr_we_i,
  input  logic                       data_we_i,
  input  logic                       asst_we_i,
  input  logic                       assoc_we_i,
  input  logic [31:0]                wdata_i,
  input  logic [ASID_W-1:0]          cur_asid_i,
  output logic [31:0]                rd_addr_o,
  output logic [31:0]                rd_data_o,
  output logic [ASST_W-1:0]          rd_asst_o,
  output logic [ENTRIES-1:0]         sync_o
);

  localparam int unsigned IW = $clog2(ENTRIES);

  logic [31:0]       addr_q [ENTRIES];
  logic [31:0]       data_q [ENTRIES];
  logic [ASST_W-1:0] asst_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, drt_q, match, touch, sync_q;

  logic idx_we;
  assign idx_we = addr_we_i | data_we_i | asst_we_i;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = (idx_i == IW'(g));
    assign match[g] = vld_q[g]
                   && (addr_q[g][31:VPN_LSB] == wdata_i[31:VPN_LSB])
                   && (data_q[g][SHARED_BIT] || addr_q[g][ASID_W-1:0] == cur_asid_i);
    assign touch[g] = (idx_we && sel) || (assoc_we_i && match[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[g] <= '0;
        data_q[g] <= '0;
        asst_q[g] <= '0;
        vld_q[g]  <= 1'b0;
        drt_q[g]  <= 1'b0;
      end else if (sel && addr_we_i) begin
        addr_q[g] <= wdata_i & ADDR_KEEP;
        vld_q[g]  <= wdata_i[VLD_BIT];
        if (HAS_DIRTY) drt_q[g] <= wdata_i[DRT_BIT];
      end else if (sel && data_we_i) begin
        data_q[g] <= wdata_i;
      end else if (sel && asst_we_i) begin
        asst_q[g] <= wdata_i[ASST_W-1:0];
      end else if (assoc_we_i && match[g]) begin
        vld_q[g] <= wdata_i[VLD_BIT];
        if (HAS_DIRTY) drt_q[g] <= wdata_i[DRT_BIT];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= touch;
  end

  always_comb begin
    rd_addr_o = addr_q[idx_i];
    rd_addr_o[VLD_BIT] = vld_q[idx_i];
    rd_addr_o[DRT_BIT] = HAS_DIRTY ? drt_q[idx_i] : 1'b0;
  end
  assign rd_data_o = data_q[idx_i];
  assign rd_asst_o = asst_q[idx_i];
  assign sync_o    = sync_q;

  // R8
  sync_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idx_we && !assoc_we_i) |=> (sync_o == '0));

  // R4
  idx_valid_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_we_i |=> (vld_q[$past(idx_i)] == $past(wdata_i[VLD_BIT])));

  // R6
  asst_keeps_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asst_we_i |=> (data_q[$past(idx_i)] == $past(data_q[idx_i])));

  // R5
  assoc_sync_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    assoc_we_i |=> (sync_o == $past(match)));

endmodule

// File: rtl/tlb_mmio_port.sv
module tlb_mmio_port
  import tlb_port_pkg::*;
#(
  parameter int unsigned ITLB_N  = 4,
  parameter int unsigned UTLB_N  = 64,
  parameter int unsigned IDX_LSB = 8,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned ASST_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [31:0]       addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  output logic [31:0]       rdata_o,
  output logic [ITLB_N-1:0] itlb_sync_o,
  output logic [UTLB_N-1:0] utlb_sync_o
);

  localparam int unsigned IIW = $clog2(ITLB_N);
  localparam int unsigned UIW = $clog2(UTLB_N);

  wr_sel_t wsel;
  rd_src_e rsel;
  logic [31:0] i_addr, i_data, u_addr, u_data;
  logic [ASST_W-1:0] i_asst, u_asst;
  logic [31:0] rd_mux, rdata_q;

  logic unused_addr;
  assign unused_addr = ^{addr_i[22:IDX_LSB+UIW], addr_i[6:0]};

  tlb_port_decode u_dec (
    .req_i       (req_i),
    .we_i        (we_i),
    .region_i    (addr_i[31:24]),
    .part_sel_i  (addr_i[23]),
    .assoc_sel_i (addr_i[7]),
    .wsel_o      (wsel),
    .rsel_o      (rsel)
  );

  tlb_entry_bank #(.ENTRIES(ITLB_N), .HAS_DIRTY(1'b0), .ASID_W(ASID_W), .ASST_W(ASST_W)) u_itlb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (addr_i[IDX_LSB +: IIW]),
    .addr_we_i  (wsel.i_addr_we),
    .data_we_i  (wsel.i_data_we),
    .asst_we_i  (wsel.i_asst_we),
    .assoc_we_i (wsel.assoc_we),
    .wdata_i    (wdata_i),
    .cur_asid_i (cur_asid_i),
    .rd_addr_o  (i_addr),
    .rd_data_o  (i_data),
    .rd_asst_o  (i_asst),
    .sync_o     (itlb_sync_o)
  );

  tlb_entry_bank #(.ENTRIES(UTLB_N), .HAS_DIRTY(1'b1), .ASID_W(ASID_W), .ASST_W(ASST_W)) u_utlb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (addr_i[IDX_LSB +: UIW]),
    .addr_we_i  (wsel.u_addr_we),
    .data_we_i  (wsel.u_data_we),
    .asst_we_i  (wsel.u_asst_we),
    .assoc_we_i (wsel.assoc_we),
    .wdata_i    (wdata_i),
    .cur_asid_i (cur_asid_i),
    .rd_addr_o  (u_addr),
    .rd_data_o  (u_data),
    .rd_asst_o  (u_asst),
    .sync_o     (utlb_sync_o)
  );

  always_comb begin
    case (rsel)
      RD_IADDR: rd_mux = i_addr;
      RD_IDATA: rd_mux = i_data;
      RD_IASST: rd_mux = 32'(i_asst);
      RD_UADDR: rd_mux = u_addr;
      RD_UDATA: rd_mux = u_data;
      RD_UASST: rd_mux = 32'(u_asst);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  // R1
  unknown_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && rsel == RD_NONE) |=> (rdata_o == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  // R3
  itlb_no_dirty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[31:24] == 8'hF2) |=> (rdata_o[9] == 1'b0));

  // R1
  unknown_write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && rsel == RD_NONE && wsel == '0) |=>
      (itlb_sync_o == '0 && utlb_sync_o == '0));

endmodule

// File: tb/sim_tlb_mmio_port.sv
module sim_tlb_mmio_port;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NU = 64;
  localparam int NT = NI + NU;
  localparam logic [31:0] KEEP = 32'hFFFF_FCFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [7:0] asid = '0;
  logic [31:0] rdata;
  logic [NI-1:0] isync;
  logic [NU-1:0] usync;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_mmio_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .cur_asid_i(asid), .rdata_o(rdata),
    .itlb_sync_o(isync), .utlb_sync_o(usync)
  );

  logic [31:0] m_a [NT];
  logic [31:0] m_dt [NT];
  logic [3:0]  m_as [NT];
  logic        m_v [NT];
  logic        m_d [NT];
  int nchk = 0, nbad = 0;
  bit done = 0;

  task automatic chk(string tag, logic [67:0] act, logic [67:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int ent(logic [31:0] a);
    return (a[31:24] == 8'hF2 || a[31:24] == 8'hF3) ? int'(a[9:8]) : NI + int'(a[13:8]);
  endfunction

  function automatic logic [31:0] exp_rd(logic [31:0] a);
    int k = ent(a);
    case (a[31:24])
      8'hF2: return m_a[k] | (32'(m_v[k]) << 8);
      8'hF6: return m_a[k] | (32'(m_v[k]) << 8) | (32'(m_d[k]) << 9);
      8'hF3, 8'hF7: return a[23] ? 32'(m_as[k]) : m_dt[k];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [67:0] model_wr(logic [31:0] a, logic [31:0] w, logic [7:0] cur);
    logic [67:0] s = '0;
    int k = ent(a);
    case (a[31:24])
      8'hF2: begin m_a[k] = w & KEEP; m_v[k] = w[8]; s[k] = 1'b1; end
      8'hF3, 8'hF7: begin
        if (a[23]) m_as[k] = w[3:0]; else m_dt[k] = w;
        s[k] = 1'b1;
      end
      8'hF6: if (a[7]) begin
        for (int j = 0; j < NT; j++)
          s[j] = m_v[j] && (m_a[j][31:10] == w[31:10]) && (m_dt[j][1] || m_a[j][7:0] == cur);
        for (int j = 0; j < NT; j++)
          if (s[j]) begin m_v[j] = w[8]; m_d[j] = w[9]; end
      end else begin
        m_a[k] = w & KEEP; m_v[k] = w[8]; m_d[k] = w[9]; s[k] = 1'b1;
      end
      default: ;
    endcase
    return s;
  endfunction

  task automatic access(string tag, logic w_en, logic [31:0] a, logic [31:0] w, logic [7:0] cur);
    logic [31:0] erd;
    logic [67:0] es = '0;
    logic [31:0] prev = rdata;
    @(negedge clk);
    req = 1'b1; we = w_en; addr = a; wdata = w; asid = cur;
    if (w_en) es = model_wr(a, w, cur);
    else      erd = exp_rd(a);
    @(negedge clk);
    req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    if (!w_en) chk({tag, " R10 rdata"}, 68'(rdata), 68'(erd));
    else       chk({tag, " R10 rdata held"}, 68'(rdata), 68'(prev));
    chk({tag, " R8 sync"}, {usync, isync}, es);
  endtask

  function automatic logic [31:0] addr_word(logic [1:0] vp, logic [1:0] vd, logic asel);
    logic [21:0] vpn = (vp == 0) ? 22'h15 : (vp == 1) ? 22'h2A : 22'h3FFFFF;
    return {vpn, vd, asel ? 8'h11 : 8'h22};
  endfunction

  initial begin
    for (int j = 0; j < NT; j++) begin
      m_a[j] = '0; m_dt[j] = '0; m_as[j] = '0; m_v[j] = 1'b0; m_d[j] = 1'b0;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 rdata", 68'(rdata), 68'h0);
    chk("R9 sync", {usync, isync}, 68'h0);
    access("R9 utlb addr", 1'b0, 32'hF600_3F00, 0, 0);
    access("R9 itlb data", 1'b0, 32'hF300_0200, 0, 0);
    // R4 / R3 / R2 boundary indices
    access("R4 u63 wr", 1'b1, 32'hF600_3F00, 32'hFFFF_FFFF, 0);
    access("R3 u63 rd", 1'b0, 32'hF600_3F00, 0, 0);
    access("R4 i3 wr", 1'b1, 32'hF200_0380, 32'hFFFF_FFFF, 0);
    access("R3 i3 rd", 1'b0, 32'hF200_0300, 0, 0);
    access("R2 u0 rd", 1'b0, 32'hF600_0000, 0, 0);
    // R6 / R7 assistance vs data
    access("R6 i1 data", 1'b1, 32'hF300_0100, 32'hDEAD_BEEF, 0);
    access("R6 i1 asst", 1'b1, 32'hF380_0100, 32'h1234_567A, 0);
    access("R7 i1 data rd", 1'b0, 32'hF300_0100, 0, 0);
    access("R7 i1 asst rd", 1'b0, 32'hF380_0100, 0, 0);
    // R1 unknown region
    access("R1 wr F4", 1'b1, 32'hF400_0100, 32'hFFFF_FFFF, 0);
    access("R1 rd F4", 1'b0, 32'hF400_0100, 0, 0);
    access("R1 rd FF", 1'b0, 32'hFF00_0000, 0, 0);
    access("R1 i1 unchanged", 1'b0, 32'hF300_0100, 0, 0);
    // R5 associative across both arrays
    access("R5 setup u5", 1'b1, 32'hF600_0500, addr_word(1, 2'b01, 1), 0);
    access("R5 setup u9", 1'b1, 32'hF600_0900, addr_word(1, 2'b11, 0), 0);
    access("R5 setup i2", 1'b1, 32'hF200_0200, addr_word(1, 2'b01, 1), 0);
    access("R5 assoc", 1'b1, 32'hF600_0080, addr_word(1, 2'b10, 1), 8'h11);
    access("R5 u5 rd", 1'b0, 32'hF600_0500, 0, 0);
    access("R5 u9 rd", 1'b0, 32'hF600_0900, 0, 0);
    access("R5 i2 rd", 1'b0, 32'hF200_0200, 0, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 10;
      logic w_en = $urandom % 2;
      logic [7:0] rg;
      logic [31:0] a, w;
      logic [7:0] cur = ($urandom % 2) ? 8'h11 : 8'h22;
      case (r)
        0, 1: rg = 8'hF2;
        2:    rg = 8'hF3;
        3, 4, 5: rg = 8'hF6;
        6, 7: rg = 8'hF7;
        default: rg = (r == 8) ? 8'hF4 : 8'hE1;
      endcase
      a = {rg, 24'($urandom)};
      if (rg == 8'hF2 || rg == 8'hF6) w = addr_word(2'($urandom % 3), 2'($urandom), 1'($urandom));
      else w = $urandom;
      access("R5 R6 R7 random", w_en, a, w, cur);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog R10 act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

endmodule